// File: doc/BRIEF.md
# Interrupt Controller with Group Summary

This block collects up to 256 interrupt lines (200 by default) and turns them into two processor requests: a fast request and a normal request. Every source has four configuration bits of its own: a sense kind (level or edge), an inversion bit that chooses active-high or active-low, an enable bit, and a route bit that picks the fast or the normal output. Edge-kind sources latch a pending bit when they trigger. Software removes that bit by writing a one to the matching position of a write-only clear bank.

Software uses a single-cycle synchronous register port. The address holds a bank number in its upper three bits and a word index in its lower three bits, and each word covers 32 sources. Two read-only banks report the masked fast and normal requests. A summary word lists the 32-source groups that currently hold a fast or normal request, so an interrupt handler can read only the status word it needs.

Top module: `intc_group_top`

## Requirements
- R1: After reset, every route bit reads 1 (normal output), every enable, inversion and kind bit reads 0, and both request outputs are low.
- R2: The address is {bank[2:0], word[2:0]}. The banks are: 0 kind, 1 inversion, 2 route, 3 enable, 4 clear, 5 fast status, 6 normal status, 7 summary. In the word that holds the last sources, only the bits that map to existing sources can be written. The other bits read 0. Word indexes beyond the last source word read 0 and ignore writes.
- R3: When a source's inversion bit is 1, a low input counts as active. When the bit is 0, a high input counts as active.
- R4: For a level-kind source (kind bit 0), the status bit follows the inverted-as-configured input in the same cycle. Clear writes have no effect on it.
- R5: For an edge-kind source (kind bit 1), a rising edge of the normalised input sets a pending bit on the next clock. The bit stays set until a clear write puts a 1 at that source's position. Zero bits in a clear write change nothing.
- R6: When a new edge and a clear of the same source fall on the same clock, the pending bit stays set.
- R7: A source whose enable bit is 0 appears in neither status bank and cannot raise either output.
- R8: Route bit 0 sends an enabled request to the fast status bank (bank 5), and route bit 1 sends it to the normal status bank (bank 6). A request never appears in both banks.
- R9: Summary word 0 has bit g (g = 0..6) set when fast status word g is non-zero, and bit 8+g set when normal status word g is non-zero. All other bits read 0.
- R10: The fast and normal outputs equal the OR of their status banks, delayed by exactly one clock.
- R11: The clear bank reads 0. Writes to the status and summary banks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Raw interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Bank and word index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| fiqReq | output | 1 | Registered fast request |
| irqReq | output | 1 | Registered normal request |

## Verification
The hardest case to reach is a clear write and a fresh edge on the same source in the same clock cycle. To get there, the bench first sets the pending bit with one input pulse and lowers the input again, so a new rise becomes possible. It then raises the input at the same negative edge that presents the clear write, so both land on one rising edge. Routing and summary bits are checked at the two ends of the source range: a source in the first word, and the single source in the top bit of the partial last word.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int WORD_W      = 32;
  localparam int SEL_W       = 3;
  localparam int BANK_W      = 3;
  localparam int IRQ_SUM_OFS = 8;

  typedef enum logic [BANK_W-1:0] {
    BANK_KIND   = 3'd0,
    BANK_INV    = 3'd1,
    BANK_ROUTE  = 3'd2,
    BANK_ENABLE = 3'd3,
    BANK_CLEAR  = 3'd4,
    BANK_FIQ    = 3'd5,
    BANK_IRQ    = 3'd6,
    BANK_SUM    = 3'd7
  } bank_e;

  typedef struct packed {
    logic             kindWr;
    logic             invWr;
    logic             routeWr;
    logic             enableWr;
    logic             clearWr;
    logic [SEL_W-1:0] wordSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 200
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [BANK_W+SEL_W-1:0]   regAddr,
  input  logic [NUM_SRC-1:0]        kindQ,
  input  logic [NUM_SRC-1:0]        invQ,
  input  logic [NUM_SRC-1:0]        routeQ,
  input  logic [NUM_SRC-1:0]        enableQ,
  input  logic [NUM_SRC-1:0]        fiqStat,
  input  logic [NUM_SRC-1:0]        irqStat,
  input  logic [WORD_W-1:0]         summary,
  output ctrlStrobe_t               strobe,
  output logic [WORD_W-1:0]         regRdData
);
  localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = (1 << SEL_W) * WORD_W;

  bank_e            bank;
  logic [SEL_W-1:0] wordSel;
  logic             wordValid;

  assign bank      = bank_e'(regAddr[BANK_W+SEL_W-1:SEL_W]);
  assign wordSel   = regAddr[SEL_W-1:0];
  assign wordValid = int'(wordSel) < NUM_WORDS;

  function automatic logic [WORD_W-1:0] pick(input logic [NUM_SRC-1:0] v,
                                             input logic [SEL_W-1:0] idx);
    logic [PAD_W-1:0] p;
    p = PAD_W'(v);
    return p[int'(idx)*WORD_W +: WORD_W];
  endfunction

  // Write decode: one strobe per configuration bank
  always_comb begin
    strobe         = '0;
    strobe.wordSel = wordSel;
    if (regWrEn && wordValid) begin
      unique case (bank)
        BANK_KIND:   strobe.kindWr   = 1'b1;
        BANK_INV:    strobe.invWr    = 1'b1;
        BANK_ROUTE:  strobe.routeWr  = 1'b1;
        BANK_ENABLE: strobe.enableWr = 1'b1;
        BANK_CLEAR:  strobe.clearWr  = 1'b1;
        default:     ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    if (wordValid) begin
      unique case (bank)
        BANK_KIND:   regRdData = pick(kindQ, wordSel);
        BANK_INV:    regRdData = pick(invQ, wordSel);
        BANK_ROUTE:  regRdData = pick(routeQ, wordSel);
        BANK_ENABLE: regRdData = pick(enableQ, wordSel);
        BANK_FIQ:    regRdData = pick(fiqStat, wordSel);
        BANK_IRQ:    regRdData = pick(irqStat, wordSel);
        BANK_SUM:    regRdData = (wordSel == '0) ? summary : '0;
        default:     regRdData = '0;
      endcase
    end
  end

  // R2: at most one bank is written per access
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.kindWr, strobe.invWr, strobe.routeWr, strobe.enableWr, strobe.clearWr}));

  // R2: unused word indexes never produce a write
  p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> ({strobe.kindWr, strobe.invWr, strobe.routeWr,
                     strobe.enableWr, strobe.clearWr} == '0));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  ctrlStrobe_t         strobe,
  input  logic [WORD_W-1:0]   wrData,
  output logic [NUM_SRC-1:0]  kindQ,
  output logic [NUM_SRC-1:0]  invQ,
  output logic [NUM_SRC-1:0]  routeQ,
  output logic [NUM_SRC-1:0]  enableQ,
  output logic [NUM_SRC-1:0]  fiqStat,
  output logic [NUM_SRC-1:0]  irqStat,
  output logic [WORD_W-1:0]   summary,
  output logic                fiqReq,
  output logic                irqReq
);
  localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;

  logic [NUM_SRC-1:0] selMask, wrVec, clrVec;
  logic [NUM_SRC-1:0] normIn, prevNorm, riseEdge, pending, pendNext, reqVec;
  logic [NUM_WORDS-1:0] fiqGrp, irqGrp;

  // Spread the written word over the source vector
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      selMask[i] = ((i / WORD_W) == int'(strobe.wordSel));
      wrVec[i]   = wrData[i % WORD_W];
    end
  end

  assign clrVec = strobe.clearWr ? (wrVec & selMask) : '0;

  // Configuration banks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= '0;
      invQ    <= '0;
      routeQ  <= '1;
      enableQ <= '0;
    end else begin
      if (strobe.kindWr)   kindQ   <= (kindQ   & ~selMask) | (wrVec & selMask);
      if (strobe.invWr)    invQ    <= (invQ    & ~selMask) | (wrVec & selMask);
      if (strobe.routeWr)  routeQ  <= (routeQ  & ~selMask) | (wrVec & selMask);
      if (strobe.enableWr) enableQ <= (enableQ & ~selMask) | (wrVec & selMask);
    end
  end

  // Normalise, detect edges, latch pending (new edge beats clear)
  assign normIn   = srcIn ^ invQ;
  assign riseEdge = normIn & ~prevNorm;
  assign pendNext = (pending & ~clrVec) | (riseEdge & kindQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevNorm <= '0;
      pending  <= '0;
    end else begin
      prevNorm <= normIn;
      pending  <= pendNext;
    end
  end

  assign reqVec  = (kindQ & pending) | (~kindQ & normIn);
  assign fiqStat = reqVec & enableQ & ~routeQ;
  assign irqStat = reqVec & enableQ &  routeQ;

  // Per-group summary
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gen_group
    localparam int LO   = g * WORD_W;
    localparam int BITS = (NUM_SRC - LO < WORD_W) ? (NUM_SRC - LO) : WORD_W;
    assign fiqGrp[g] = |fiqStat[LO +: BITS];
    assign irqGrp[g] = |irqStat[LO +: BITS];
  end

  always_comb begin
    summary = '0;
    summary[NUM_WORDS-1:0] = fiqGrp;
    summary[IRQ_SUM_OFS +: NUM_WORDS] = irqGrp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fiqReq <= 1'b0;
      irqReq <= 1'b0;
    end else begin
      fiqReq <= |fiqGrp;
      irqReq <= |irqGrp;
    end
  end

  // R5: every edge on an edge-kind source is pending one clock later
  p_edge_latched_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseEdge & kindQ) & ~pending) == '0));

  // R5: a pending bit only appears after an edge
  p_pending_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(riseEdge)) == '0));

  // R4: a level request needs an active normalised input
  p_level_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((fiqStat | irqStat) & ~kindQ & ~normIn) == '0);

  // R7: disabled sources never reach status
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((fiqStat | irqStat) & ~enableQ) == '0);

  // R8: a request sits in only one status bank
  p_route_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fiqStat & irqStat) == '0);

  // R9: summary agrees with status
  p_summary_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((summary[NUM_WORDS-1:0] != '0) == (fiqStat != '0)) &&
    ((summary[IRQ_SUM_OFS +: NUM_WORDS] != '0) == (irqStat != '0)));

  // R10: outputs lag status by one clock
  p_fiq_delay_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fiqReq == $past(fiqStat != '0)));
  p_irq_delay_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqReq == $past(irqStat != '0)));
endmodule

// File: rtl/intc_group_top.sv
module intc_group_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       srcIn,
  input  logic                     regWrEn,
  input  logic [BANK_W+SEL_W-1:0]  regAddr,
  input  logic [WORD_W-1:0]        regWrData,
  output logic [WORD_W-1:0]        regRdData,
  output logic                     fiqReq,
  output logic                     irqReq
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] kindQ, invQ, routeQ, enableQ, fiqStat, irqStat;
  logic [WORD_W-1:0]  summary;

  intc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .kindQ     (kindQ),
    .invQ      (invQ),
    .routeQ    (routeQ),
    .enableQ   (enableQ),
    .fiqStat   (fiqStat),
    .irqStat   (irqStat),
    .summary   (summary),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strobe  (strobe),
    .wrData  (regWrData),
    .kindQ   (kindQ),
    .invQ    (invQ),
    .routeQ  (routeQ),
    .enableQ (enableQ),
    .fiqStat (fiqStat),
    .irqStat (irqStat),
    .summary (summary),
    .fiqReq  (fiqReq),
    .irqReq  (irqReq)
  );
endmodule

// File: tb/sim_intc_group_top.sv
`timescale 1ns/1ps
module sim_intc_group_top;
  localparam int NSRC = 200;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic            regWrEn = 1'b0;
  logic [5:0]      regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            fiqReq, irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  intc_group_top #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fiqReq(fiqReq), .irqReq(irqReq)
  );

  // {addr, write data, expected read}
  localparam logic [69:0] VEC [7] = '{
    {6'h00, 32'hA5A50F0F, 32'hA5A50F0F},  // R2 kind word 0
    {6'h06, 32'hFFFFFFFF, 32'h000000FF},  // R2 partial last word
    {6'h0A, 32'h12345678, 32'h12345678},  // R3 inversion storage
    {6'h21, 32'hFFFFFFFF, 32'h00000000},  // R11 clear reads zero
    {6'h28, 32'hFFFFFFFF, 32'h00000000},  // R11 status not writable
    {6'h07, 32'hFFFFFFFF, 32'h00000000},  // R2 unused word
    {6'h38, 32'hFFFFFFFF, 32'h00000000}   // R11 summary not writable
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a negative edge; returns after the next one
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 reset state
    rd(6'h10, d); chk("R1 route w0", d, 32'hFFFFFFFF);
    rd(6'h16, d); chk("R1 route w6", d, 32'h000000FF);
    rd(6'h18, d); chk("R1 enable w0", d, 32'h0);
    rd(6'h08, d); chk("R1 inv w0", d, 32'h0);
    rd(6'h00, d); chk("R1 kind w0", d, 32'h0);
    chk("R1 fiqReq", {31'b0, fiqReq}, 32'h0);
    chk("R1 irqReq", {31'b0, irqReq}, 32'h0);

    // Table walk
    for (int k = 0; k < 7; k++) begin
      wr(VEC[k][69:64], VEC[k][63:32]);
      rd(VEC[k][69:64], d);
      chk($sformatf("R2/R11 vector %0d", k), d, VEC[k][31:0]);
    end
    wr(6'h00, 32'h0); wr(6'h06, 32'h0); wr(6'h0A, 32'h0);

    // Level source 5 on fast output (R4, R8, R9, R10)
    wr(6'h10, 32'hFFFFFFDF);
    wr(6'h18, 32'h00000020);
    srcIn[5] = 1'b1;
    rd(6'h28, d); chk("R4 level status same cycle", d, 32'h20);
    chk("R10 fiqReq not yet", {31'b0, fiqReq}, 32'h0);
    rd(6'h30, d); chk("R8 normal bank empty", d, 32'h0);
    rd(6'h38, d); chk("R9 summary fast group 0", d, 32'h1);
    step(); chk("R10 fiqReq after one clock", {31'b0, fiqReq}, 32'h1);
    wr(6'h20, 32'h20);
    rd(6'h28, d); chk("R4 clear ignored for level", d, 32'h20);
    srcIn[5] = 1'b0;
    rd(6'h28, d); chk("R4 level drops", d, 32'h0);
    step(); chk("R10 fiqReq falls", {31'b0, fiqReq}, 32'h0);
    wr(6'h18, 32'h0); wr(6'h10, 32'hFFFFFFFF);

    // Active-low source 40 (R3, R9)
    wr(6'h09, 32'h100);
    wr(6'h19, 32'h100);
    rd(6'h31, d); chk("R3 low input active", d, 32'h100);
    rd(6'h38, d); chk("R9 summary normal group 1", d, 32'h200);
    srcIn[40] = 1'b1;
    rd(6'h31, d); chk("R3 high input idle", d, 32'h0);
    wr(6'h19, 32'h0); wr(6'h09, 32'h0);
    srcIn[40] = 1'b0;

    // Edge source 100 = word 3 bit 4 (R5)
    wr(6'h03, 32'h10);
    wr(6'h1B, 32'h10);
    srcIn[100] = 1'b1;
    rd(6'h33, d); chk("R5 not pending before clock", d, 32'h0);
    step(); srcIn[100] = 1'b0;
    rd(6'h33, d); chk("R5 pending sticky", d, 32'h10);
    wr(6'h23, 32'h0);
    rd(6'h33, d); chk("R5 zero clear no effect", d, 32'h10);
    wr(6'h23, 32'hFFFFFFEF);
    rd(6'h33, d); chk("R5 other bits no effect", d, 32'h10);
    wr(6'h23, 32'h10);
    rd(6'h33, d); chk("R5 cleared", d, 32'h0);

    // Edge and clear together (R6)
    srcIn[100] = 1'b1; step(); srcIn[100] = 1'b0; step();
    rd(6'h33, d); chk("R6 pending before collision", d, 32'h10);
    srcIn[100] = 1'b1;
    wr(6'h23, 32'h10);
    rd(6'h33, d); chk("R6 edge wins over clear", d, 32'h10);
    srcIn[100] = 1'b0;
    wr(6'h23, 32'h10);
    rd(6'h33, d); chk("R6 later clear works", d, 32'h0);
    wr(6'h03, 32'h0); wr(6'h1B, 32'h0);

    // Last source 199 = word 6 bit 7 (R7, R8, R9, R10, R2)
    srcIn[199] = 1'b1;
    rd(6'h36, d); chk("R7 masked normal", d, 32'h0);
    rd(6'h2E, d); chk("R7 masked fast", d, 32'h0);
    step(); chk("R7 irqReq stays low", {31'b0, irqReq}, 32'h0);
    wr(6'h1E, 32'h80);
    rd(6'h36, d); chk("R7 enabled normal", d, 32'h80);
    rd(6'h38, d); chk("R9 summary normal group 6", d, 32'h4000);
    step(); chk("R10 irqReq high", {31'b0, irqReq}, 32'h1);
    wr(6'h16, 32'hFFFFFF7F);
    rd(6'h16, d); chk("R2 route w6 upper bits", d, 32'h7F);
    rd(6'h2E, d); chk("R8 rerouted to fast", d, 32'h80);
    rd(6'h36, d); chk("R8 normal now empty", d, 32'h0);
    rd(6'h38, d); chk("R9 summary fast group 6", d, 32'h40);
    step();
    chk("R10 fiqReq high", {31'b0, fiqReq}, 32'h1);
    chk("R10 irqReq low", {31'b0, irqReq}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule